// File: doc/BRIEF.md
# Write-Back Cache Flush Sequencer

This block runs a complete flush of a write-back data cache. A flush request is taken only in a cycle that is also an instruction boundary, much as an interrupt would be. The block then waits until no fill or write-back is still in flight on the bus. After that it walks the tag/state array from line 0 upward, at one line per bus clock. The core clock runs `CLK_RATIO` times faster than the bus clock, so each line holds the scan for `CLK_RATIO` core cycles.

Every modified line found during the walk is handed to the bus unit as a burst write-back. The walk stalls until that handshake completes. When the last line has been visited, the block issues two acknowledge special cycles, one after the other, so the system can see that the write-backs are over. It then invalidates the whole array in a single step and pulses a completion output. A clean cache still costs `NUM_LINES * CLK_RATIO` scan cycles. Cache geometry and clock ratio are parameters.

Top module: `flush_seq`

## Requirements
- R1: In idle, `flush_req` is taken only in a cycle where `instr_bnd` is also 1. A request held with `instr_bnd` at 0 has no effect: `arr_rd` and every other output stay 0.
- R2: After a request is taken, the scan does not start while `bus_busy` is 1. `arr_rd` rises in the cycle after the first clock edge that sees `bus_busy` at 0.
- R3: The scan presents line indices on `arr_idx` in strictly ascending order, starting at 0. Each line is presented with `arr_rd` at 1 for exactly `CLK_RATIO` cycles, so one flush shows `NUM_LINES * CLK_RATIO` cycles of `arr_rd`.
- R4: `arr_dirty` is sampled in the last scan cycle of a line, where 1 means modified. For a modified line, `wb_req` is raised and held with `wb_idx` equal to that line until `wb_done` is seen. One write-back occurs per modified line, in ascending line order.
- R5: No special cycle and no invalidate occurs before every write-back of the flush has completed. `arr_rd`, `wb_req`, `spc_req` and `arr_inv_all` are never 1 together.
- R6: After the scan, exactly two special cycles are issued: first with `spc_seq`=0, then with `spc_seq`=1. Each is held until `spc_rdy` is seen.
- R7: `arr_inv_all` pulses for one cycle in the cycle after the second special cycle is accepted. `flush_done` pulses for one cycle in the cycle after that.
- R8: A `flush_req` (even with `instr_bnd`) arriving while a flush is under way is ignored. That flush ends with exactly one `flush_done` pulse and exactly two special cycles.
- R9: After reset all outputs are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_req | input | 1 | Flush request level |
| instr_bnd | input | 1 | Instruction-boundary strobe |
| bus_busy | input | 1 | A fill or write-back is still outstanding |
| arr_rd | output | 1 | Scan read of the tag/state array |
| arr_idx | output | IDX_W | Line index being scanned |
| arr_dirty | input | 1 | State of line `arr_idx` is modified |
| arr_inv_all | output | 1 | One-cycle global invalidate |
| wb_req | output | 1 | Burst write-back request |
| wb_idx | output | IDX_W | Line to write back |
| wb_done | input | 1 | Burst write-back finished |
| spc_req | output | 1 | Acknowledge special cycle request |
| spc_seq | output | 1 | Which acknowledge (0 first, 1 second) |
| spc_rdy | input | 1 | Special cycle completed |
| flush_done | output | 1 | One-cycle flush completion pulse |

## Verification
A fresh flush request can arrive at an instruction boundary in the same cycle that an earlier flush is scanning or waiting on a write-back. The bench provokes this by pulsing `flush_req` with `instr_bnd` in the middle of a flush that has random dirty lines. It then judges the outcome by the count of completion pulses and acknowledge cycles, and by the scan cycle count for that flush. A second overlap is a write-back completing on the very line that ends the scan. The bench forces this by making the top line dirty, then checks that the acknowledge cycles start only after that write-back's handshake.

// File: rtl/flush_pkg.sv
package flush_pkg;
    typedef enum logic [2:0] {
        FS_IDLE,
        FS_PEND,
        FS_SCAN,
        FS_WB,
        FS_ACK0,
        FS_ACK1,
        FS_INV,
        FS_DONE
    } fs_state_e;
endpackage

// File: rtl/flush_gate.sv
module flush_gate (
    input  logic flush_req,
    input  logic instr_bnd,
    input  logic bus_busy,
    input  logic is_idle,
    input  logic is_pend,
    output logic accept,
    output logic start
);
    // A request counts only at an instruction boundary while idle.
    assign accept = is_idle & flush_req & instr_bnd;
    // The scan may begin once nothing is outstanding on the bus.
    assign start  = is_pend & ~bus_busy;
endmodule

// File: rtl/flush_pace.sv
module flush_pace #(
    parameter int RATIO = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (RATIO <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(RATIO);
            localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                tick  = 1'b0;
                if (!run) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    tick  = 1'b1;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            AST_PACE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= LAST);                                  // R3
            AST_PACE_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> cnt_q == '0);                           // R3
        end
    endgenerate
endmodule

// File: rtl/flush_seq.sv
module flush_seq
    import flush_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int CLK_RATIO = 2,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_req,
    input  logic             instr_bnd,
    input  logic             bus_busy,
    output logic             arr_rd,
    output logic [IDX_W-1:0] arr_idx,
    input  logic             arr_dirty,
    output logic             arr_inv_all,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx,
    input  logic             wb_done,
    output logic             spc_req,
    output logic             spc_seq,
    input  logic             spc_rdy,
    output logic             flush_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    typedef struct packed {
        fs_state_e        state;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept, start, tick, at_last;

    flush_gate u_gate (
        .flush_req (flush_req),
        .instr_bnd (instr_bnd),
        .bus_busy  (bus_busy),
        .is_idle   (seq_q.state == FS_IDLE),
        .is_pend   (seq_q.state == FS_PEND),
        .accept    (accept),
        .start     (start)
    );

    flush_pace #(.RATIO(CLK_RATIO)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (seq_q.state == FS_SCAN),
        .tick  (tick)
    );

    assign at_last = (seq_q.idx == LAST_IDX);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            FS_IDLE: if (accept) seq_d.state = FS_PEND;
            FS_PEND: if (start) begin
                seq_d.state = FS_SCAN;
                seq_d.idx   = '0;
            end
            FS_SCAN: if (tick) begin
                if (arr_dirty)    seq_d.state = FS_WB;
                else if (at_last) seq_d.state = FS_ACK0;
                else              seq_d.idx   = seq_q.idx + 1'b1;
            end
            FS_WB: if (wb_done) begin
                if (at_last) begin
                    seq_d.state = FS_ACK0;
                end else begin
                    seq_d.state = FS_SCAN;
                    seq_d.idx   = seq_q.idx + 1'b1;
                end
            end
            FS_ACK0: if (spc_rdy) seq_d.state = FS_ACK1;
            FS_ACK1: if (spc_rdy) seq_d.state = FS_INV;
            FS_INV:  seq_d.state = FS_DONE;
            FS_DONE: seq_d.state = FS_IDLE;
            default: seq_d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= FS_IDLE;
            seq_q.idx   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign arr_rd      = (seq_q.state == FS_SCAN);
    assign arr_idx     = seq_q.idx;
    assign wb_req      = (seq_q.state == FS_WB);
    assign wb_idx      = seq_q.idx;
    assign spc_req     = (seq_q.state == FS_ACK0) || (seq_q.state == FS_ACK1);
    assign spc_seq     = (seq_q.state == FS_ACK1);
    assign arr_inv_all = (seq_q.state == FS_INV);
    assign flush_done  = (seq_q.state == FS_DONE);

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == FS_PEND && bus_busy) |=> !arr_rd);                 // R2
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_done) |=> (wb_req && $stable(wb_idx)));              // R4
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_rd, wb_req, spc_req, arr_inv_all}));                  // R5
    AST_SPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (spc_req && !spc_rdy) |=> (spc_req && $stable(spc_seq)));           // R6
    AST_SPC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (spc_req && !spc_seq && spc_rdy) |=> (spc_req && spc_seq));         // R6
    AST_INV_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (spc_req && spc_seq && spc_rdy) |=> arr_inv_all);                   // R7
    AST_DONE_AFTER_INV: assert property (@(posedge clk) disable iff (!rst_n)
        arr_inv_all |=> (flush_done && !arr_inv_all));                      // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);                                        // R8
    AST_SCAN_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && $past(arr_rd)) |-> (arr_idx >= $past(arr_idx)));         // R3
endmodule

// File: tb/sim_flush_seq.sv
module sim_flush_seq;
    localparam int N      = 64;
    localparam int R      = 2;
    localparam int IW     = $clog2(N);
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_req = 1'b0, instr_bnd = 1'b0, bus_busy = 1'b0;
    logic wb_done = 1'b0, spc_rdy = 1'b0;
    logic arr_rd, arr_inv_all, wb_req, spc_req, spc_seq, flush_done;
    logic [IW-1:0] arr_idx, wb_idx;
    logic arr_dirty;

    logic mod_bits [N];
    logic val_bits [N];

    int checks = 0, fails = 0, cycles = 0;
    int rd_cnt, wb_cnt, spc_cnt, inv_cnt, done_cnt, ord_err, scan_err, prev_rd;
    int wb_log [N];
    int spc_log [4];
    int wb_lat, wb_wait, spc_lat, spc_wait;

    always #(CLK_PERIOD/2) clk = ~clk;

    flush_seq #(.NUM_LINES(N), .CLK_RATIO(R)) u0 (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .instr_bnd(instr_bnd),
        .bus_busy(bus_busy), .arr_rd(arr_rd), .arr_idx(arr_idx), .arr_dirty(arr_dirty),
        .arr_inv_all(arr_inv_all), .wb_req(wb_req), .wb_idx(wb_idx), .wb_done(wb_done),
        .spc_req(spc_req), .spc_seq(spc_seq), .spc_rdy(spc_rdy), .flush_done(flush_done)
    );

    assign arr_dirty = mod_bits[arr_idx] & val_bits[arr_idx];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (arr_inv_all)
            for (int i = 0; i < N; i++) begin
                val_bits[i] <= 1'b0;
                mod_bits[i] <= 1'b0;
            end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_stats();
        rd_cnt = 0; wb_cnt = 0; spc_cnt = 0; inv_cnt = 0; done_cnt = 0;
        ord_err = 0; scan_err = 0; prev_rd = -1;
    endtask

    // Monitor and bus responders, all on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (arr_rd) begin
                rd_cnt++;
                if (int'(arr_idx) < prev_rd) scan_err++;
                prev_rd = int'(arr_idx);
            end
            if (spc_req && wb_req) ord_err++;
            if (wb_req && spc_cnt > 0) ord_err++;
            if (arr_inv_all) begin
                inv_cnt++;
                if (spc_cnt != 2) ord_err++;
            end
            if (flush_done) begin
                done_cnt++;
                if (inv_cnt == 0) ord_err++;
            end
            if (wb_done) begin
                wb_done = 1'b0; wb_wait = 0; wb_lat = $urandom_range(0, 3);
            end else if (wb_req) begin
                if (wb_wait >= wb_lat) begin
                    wb_done = 1'b1;
                    if (wb_cnt < N) wb_log[wb_cnt] = int'(wb_idx);
                    wb_cnt++;
                end else wb_wait++;
            end
            if (spc_rdy) begin
                spc_rdy = 1'b0; spc_wait = 0; spc_lat = $urandom_range(0, 3);
            end else if (spc_req) begin
                if (spc_wait >= spc_lat) begin
                    spc_rdy = 1'b1;
                    if (spc_cnt < 4) spc_log[spc_cnt] = int'(spc_seq);
                    spc_cnt++;
                end else spc_wait++;
            end
        end
    end

    task automatic run_flush(input logic [N-1:0] pat, input int busy_cyc, input bit extra_req);
        int exp_wb;
        int k;
        bit order_ok;
        int waited;
        for (int i = 0; i < N; i++) begin
            mod_bits[i] = pat[i];
            val_bits[i] = 1'b1;
        end
        exp_wb = $countones(pat);
        clear_stats();
        @(negedge clk);
        flush_req = 1'b1; instr_bnd = 1'b1; bus_busy = (busy_cyc > 0);
        @(negedge clk);
        flush_req = 1'b0; instr_bnd = 1'b0;
        if (busy_cyc > 0) begin
            repeat (busy_cyc) @(negedge clk);
            chk(rd_cnt == 0 && !arr_rd, "R2 no scan while bus busy", rd_cnt, 0);
            bus_busy = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk(arr_rd == 1'b1, "R2 scan starts after bus idle", arr_rd, 1);
        end
        if (extra_req) begin
            repeat (N) @(negedge clk);
            flush_req = 1'b1; instr_bnd = 1'b1;
            @(negedge clk);
            flush_req = 1'b0; instr_bnd = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        repeat (20) @(negedge clk);
        chk(rd_cnt == N * R, "R3 scan cycle count", rd_cnt, N * R);
        chk(scan_err == 0, "R3 ascending scan", scan_err, 0);
        chk(wb_cnt == exp_wb, "R4 write-back count", wb_cnt, exp_wb);
        k = 0; order_ok = 1'b1;
        for (int i = 0; i < N; i++)
            if (pat[i]) begin
                if (k >= wb_cnt || wb_log[k] != i) order_ok = 1'b0;
                k++;
            end
        chk(order_ok, "R4 write-back order", order_ok, 1);
        chk(ord_err == 0, "R5 ordering of write-back/ack/invalidate", ord_err, 0);
        chk(spc_cnt == 2, "R6 two acknowledge cycles", spc_cnt, 2);
        chk(spc_log[0] == 0 && spc_log[1] == 1, "R6 acknowledge order",
            spc_log[0] * 10 + spc_log[1], 1);
        chk(inv_cnt == 1, "R7 single invalidate pulse", inv_cnt, 1);
        k = 0;
        for (int i = 0; i < N; i++) if (val_bits[i]) k++;
        chk(k == 0, "R7 all lines invalid", k, 0);
        chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [N-1:0] pat;
        void'($urandom(32'd20251));
        wb_lat = 1; wb_wait = 0; spc_lat = 1; spc_wait = 0;
        for (int i = 0; i < N; i++) begin
            mod_bits[i] = 1'b0;
            val_bits[i] = 1'b1;
        end
        clear_stats();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk({arr_rd, wb_req, spc_req, spc_seq, arr_inv_all, flush_done} == 6'b0,
            "R9 outputs after reset",
            int'({arr_rd, wb_req, spc_req, spc_seq, arr_inv_all, flush_done}), 0);
        // R1 request without instruction boundary
        flush_req = 1'b1; instr_bnd = 1'b0;
        repeat (12) @(negedge clk);
        flush_req = 1'b0;
        repeat (4) @(negedge clk);
        chk(rd_cnt == 0 && done_cnt == 0 && spc_cnt == 0, "R1 request ignored off boundary",
            rd_cnt + done_cnt + spc_cnt, 0);
        // Directed corners
        run_flush('0, 0, 1'b0);                                    // clean cache
        run_flush('1, 3, 1'b0);                                    // every line dirty
        pat = '0; pat[N-1] = 1'b1; pat[0] = 1'b1;
        run_flush(pat, 0, 1'b0);                                   // first and last lines
        // Random dirty patterns, one with an overlapping request (R8)
        for (int t = 0; t < 4; t++) begin
            pat = {$urandom, $urandom};
            run_flush(pat, $urandom_range(0, 5), (t == 1));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule